// File: doc/BRIEF.md
# Snoop-Control Register File

This block is the software-visible register set of a multicore snoop control unit. It has no coherency datapath. It holds three things: a one-bit enable, a read-only word that describes the core population, and a 32-bit power status word. The power status word packs one byte per core, and software reaches it one byte lane at a time.

A simple slave port drives the block. The port carries an offset, write data, a byte-count qualifier, and write and read strobes. Writes take effect at the sampling edge. Read data comes from a register that loads one cycle after the read strobe is sampled.

Some offsets belong to features this block does not provide: cache invalidation, address filtering and access control. These offsets, and every other unlisted offset, read as zero and discard writes. The core count is a parameter, and the configuration word is computed from it at elaboration.

Top module: `scu_regfile`

## Requirements
- R1: During and right after reset, the enable bit and the power status word are zero, and read data is zero.
- R2: A write of size 1, 2 or 4 at offset 0x00 stores write-data bit 0 only. A read at 0x00 returns that bit in bit 0, with bits 31:1 zero.
- R3: A read at offset 0x04 returns a field of NUM_CORES ones starting at bit 4, with NUM_CORES-1 in bits 3:0. Writes there change nothing.
- R4: A read at offset 0x08+k (k = 0..3) returns the power status word shifted right by 8*k, with zeros filled in from the top.
- R5: A write at offset 0x08+k replaces only certain bytes of the power status word. A size of 1, 2 or 4 (the qualifier holds the byte count as a binary value) selects the low 1, 2 or 4 bytes of write data. Those bytes land starting at byte lane k, and bytes that would go past lane 3 are dropped. All other bytes keep their value.
- R6: A write whose size qualifier is not 1, 2 or 4 changes neither the enable bit nor the power status word, at any offset.
- R7: Offset 0x0C, offsets 0x40, 0x44, 0x50 and 0x54, and every other offset not named in R2 to R5 read as zero and ignore writes.
- R8: Read data updates on the clock edge after the one where the read strobe is sampled, and holds its value while no read is sampled. When a read and a write are sampled together, the read returns the value held before the write.
- R9: Only address bits 7:0 select a register, and higher address bits are ignored.
- R10: NUM_CORES must lie in 1..4. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset; bits above 7 ignored |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_size | input | 3 | Access size as a byte count (1, 2 or 4 valid) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a wide write that starts at an upper byte lane. There the mask and the data run off the top of the word, and only the lanes that remain may change. To reach it, the stimulus first fills the power word with a known pattern using full-width writes. It then issues 2- and 4-byte writes at offsets 0x0A and 0x0B, and reads back both the full word and every lane view. A further step pairs an out-of-range size with each register, on top of a non-zero state, so that a rejected write would show up as a change.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;

   localparam int unsigned OFF_W    = 8;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned LANES    = WORD_W / 8;
   localparam int unsigned LANE_W   = $clog2(LANES);

   localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h00;
   localparam logic [OFF_W-1:0] OFF_CONFIG = 8'h04;
   localparam logic [OFF_W-1:0] OFF_POWER  = 8'h08;

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_CONFIG = 2'd1,
      SEL_POWER  = 2'd2,
      SEL_ZERO   = 2'd3
   } reg_sel_e;

   function automatic logic size_ok(input logic [2:0] sz);
      return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
   endfunction

   function automatic logic [LANES-1:0] size_lanes(input logic [2:0] sz);
      logic [LANES-1:0] m;
      m = '0;
      for (int i = 0; i < LANES; i++) begin
         if (i < int'(sz)) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
   import scu_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
)(
   input  logic [ADDR_W-1:0]  addr,
   output reg_sel_e           sel,
   output logic [LANE_W-1:0]  lane
);

   logic [OFF_W-1:0] off;

   assign off  = addr[OFF_W-1:0];
   assign lane = off[LANE_W-1:0];

   always_comb begin
      if (off == OFF_ENABLE)
         sel = SEL_ENABLE;
      else if (off == OFF_CONFIG)
         sel = SEL_CONFIG;
      else if (off[OFF_W-1:LANE_W] == OFF_POWER[OFF_W-1:LANE_W])
         sel = SEL_POWER;
      else
         sel = SEL_ZERO;
   end

endmodule

// File: rtl/scu_enable_reg.sv
module scu_enable_reg
   import scu_regs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  logic     size_good,
   input  reg_sel_e sel,
   input  logic     wbit,
   output logic     q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else if (wr && size_good && sel == SEL_ENABLE)
         q <= wbit;
   end

endmodule

// File: rtl/scu_power_word.sv
module scu_power_word
   import scu_regs_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [2:0]         size,
   input  reg_sel_e           sel,
   input  logic [LANE_W-1:0]  lane,
   input  logic [WORD_W-1:0]  wdata,
   output logic [WORD_W-1:0]  q
);

   logic [LANES-1:0]  lane_en;
   logic [WORD_W-1:0] data_sh;
   logic              wr_ok;

   assign wr_ok   = wr && size_ok(size) && (sel == SEL_POWER);
   assign lane_en = size_lanes(size) << lane;
   assign data_sh = wdata << {lane, 3'b000};

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[8*j +: 8] <= 8'h00;
         else if (wr_ok && lane_en[j])
            q[8*j +: 8] <= data_sh[8*j +: 8];
      end
   end

endmodule

// File: rtl/scu_read_port.sv
module scu_read_port
   import scu_regs_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  reg_sel_e           sel,
   input  logic [LANE_W-1:0]  lane,
   input  logic               enable_q,
   input  logic [WORD_W-1:0]  power_q,
   output logic [WORD_W-1:0]  rdata
);

   localparam logic [WORD_W-1:0] CORE_MASK = (WORD_W'(1) << NUM_CORES) - WORD_W'(1);
   localparam logic [WORD_W-1:0] CFG_WORD  = (CORE_MASK << 4) | WORD_W'(NUM_CORES - 1);

   logic [WORD_W-1:0] rd_val;

   always_comb begin
      unique case (sel)
         SEL_ENABLE: rd_val = {{(WORD_W-1){1'b0}}, enable_q};
         SEL_CONFIG: rd_val = CFG_WORD;
         SEL_POWER:  rd_val = power_q >> {lane, 3'b000};
         default:    rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rd_val;
   end

endmodule

// File: rtl/scu_regfile.sv
module scu_regfile
   import scu_regs_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned MAX_CORES = 4,
   parameter int unsigned ADDR_W    = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [2:0]        bus_size,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata
);

   // R10: core count range, address width floor
   if (NUM_CORES < 1 || NUM_CORES > MAX_CORES || MAX_CORES > 4) begin : g_bad_cores
      $error("scu_regfile: NUM_CORES out of range");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("scu_regfile: ADDR_W below offset width");
   end

   reg_sel_e          sel;
   logic [LANE_W-1:0] lane;
   logic              ctrl_q;
   logic [31:0]       pwr_q;

   scu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .lane (lane)
   );

   scu_enable_reg u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr),
      .size_good (size_ok(bus_size)),
      .sel       (sel),
      .wbit      (bus_wdata[0]),
      .q         (ctrl_q)
   );

   scu_power_word u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .size  (bus_size),
      .sel   (sel),
      .lane  (lane),
      .wdata (bus_wdata),
      .q     (pwr_q)
   );

   scu_read_port #(.NUM_CORES(NUM_CORES)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .sel      (sel),
      .lane     (lane),
      .enable_q (ctrl_q),
      .power_q  (pwr_q),
      .rdata    (bus_rdata)
   );

endmodule

// File: rtl/scu_regfile_chk.sv
module scu_regfile_chk #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 12
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [2:0]        bus_size,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              ctrl_q,
   input logic [31:0]       pwr_q
);

   localparam logic [31:0] CFG_EXP =
      (((32'd1 << NUM_CORES) - 32'd1) << 4) | 32'(NUM_CORES - 1);

   logic [7:0] off;
   logic       good_sz;
   logic       raz_off;

   assign off     = bus_addr[7:0];
   assign good_sz = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
   assign raz_off = (off != 8'h00) && (off != 8'h04) && (off[7:2] != 6'h02);

   a_r2_ctrl_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && bus_rd && off == 8'h00) |-> bus_rdata[31:1] == 31'd0);

   a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && good_sz && off == 8'h00) |=> ctrl_q == $past(bus_wdata[0]));

   a_r3_cfg_value: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && bus_rd && off == 8'h04) |-> bus_rdata == CFG_EXP);

   a_r6_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !good_sz) |=> ($stable(pwr_q) && $stable(ctrl_q)));

   a_r7_raz_read: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && bus_rd && raz_off) |-> bus_rdata == 32'd0);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(bus_rd)) |-> $stable(bus_rdata));

endmodule

bind scu_regfile scu_regfile_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_size  (bus_size),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .ctrl_q    (ctrl_q),
   .pwr_q     (pwr_q)
);

// File: tb/scu_regfile_test.sv
module scu_regfile_test;

   localparam int NC = 2;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [2:0]    bus_size = 3'd4;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [31:0]   bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural model state
   bit [31:0] m_ctrl  = 0;
   bit [31:0] m_pwr   = 0;
   bit [31:0] m_rdata = 0;

   always #2.5 clk = ~clk;

   scu_regfile #(.NUM_CORES(NC), .ADDR_W(AW)) uut (
      .clk, .rst_n, .bus_addr, .bus_wdata, .bus_size, .bus_wr, .bus_rd, .bus_rdata
   );

   function automatic bit [31:0] m_read(input int off);
      if (off == 0) return m_ctrl & 32'h1;
      if (off == 4) return (((32'd1 << NC) - 1) << 4) | (NC - 1);
      if (off >= 8 && off <= 11) return m_pwr >> (8 * (off - 8));
      return 0;
   endfunction

   function automatic void m_write(input int off, input bit [31:0] d, input int sz);
      bit [31:0] mask;
      if (sz == 1) mask = 32'hFF;
      else if (sz == 2) mask = 32'hFFFF;
      else if (sz == 4) mask = 32'hFFFF_FFFF;
      else return;
      if (off == 0) m_ctrl = d & 1;
      else if (off >= 8 && off <= 11) begin
         m_pwr = (m_pwr & ~(mask << (8 * (off - 8)))) | ((d & mask) << (8 * (off - 8)));
      end
   endfunction

   task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive at negedge, update model at the edge, compare at next negedge
   task automatic cyc(input string tag, input int addr, input bit [31:0] d,
                      input int sz, input bit wr, input bit rd);
      int off;
      bus_addr  = AW'(addr);
      bus_wdata = d;
      bus_size  = 3'(sz);
      bus_wr    = wr;
      bus_rd    = rd;
      off = addr & 8'hFF;
      @(posedge clk);
      if (rd) m_rdata = m_read(off);
      if (wr) m_write(off, d, sz);
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      check(tag, bus_rdata, m_rdata);
   endtask

   task automatic rd(input string tag, input int addr);
      cyc(tag, addr, 32'h0, 4, 1'b0, 1'b1);
   endtask

   task automatic wr(input string tag, input int addr, input bit [31:0] d, input int sz);
      cyc(tag, addr, d, sz, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      rd("R1 enable after reset", 12'h000);
      rd("R1 power after reset", 12'h008);

      // R3 and R10: config from NC
      rd("R3 config", 12'h004);
      check("R10 config low field", bus_rdata[3:0], 4'(NC - 1));
      wr("R3 config write", 12'h004, 32'hFFFF_FFFF, 4);
      rd("R3 config after write", 12'h004);

      // R2
      wr("R2 enable set", 12'h000, 32'hFFFF_FFFF, 4);
      rd("R2 enable read", 12'h000);
      wr("R2 enable byte clear", 12'h000, 32'hFFFF_FFFE, 1);
      rd("R2 enable cleared", 12'h000);
      wr("R2 enable set 2", 12'h000, 32'h1, 2);

      // R4/R5 full word then lane views
      wr("R5 full", 12'h008, 32'h4433_2211, 4);
      for (int k = 0; k < 4; k++) rd("R4 lane view", 12'h008 + k);
      wr("R5 byte lane1", 12'h009, 32'hFFFF_FFAA, 1);
      rd("R5 after byte", 12'h008);
      wr("R5 half lane2", 12'h00A, 32'h1234_BBCC, 2);
      rd("R5 after half", 12'h008);
      wr("R5 half lane3 truncates", 12'h00B, 32'h0000_77DD, 2);
      rd("R5 after top half", 12'h008);
      wr("R5 word lane2 truncates", 12'h00A, 32'h9988_6655, 4);
      rd("R5 after word lane2", 12'h008);
      wr("R5 word lane3", 12'h00B, 32'hABCD_EF01, 4);
      for (int k = 0; k < 4; k++) rd("R4 lane view 2", 12'h008 + k);

      // R6 bad sizes
      for (int s = 0; s < 8; s++) begin
         if (s != 1 && s != 2 && s != 4) begin
            wr("R6 bad size power", 12'h008, 32'h0, s);
            wr("R6 bad size enable", 12'h000, 32'h0, s);
         end
      end
      rd("R6 power kept", 12'h008);
      rd("R6 enable kept", 12'h000);

      // R7 zero offsets
      wr("R7 write 0c", 12'h00C, 32'hFFFF_FFFF, 4);
      rd("R7 read 0c", 12'h00C);
      wr("R7 write 40", 12'h040, 32'hFFFF_FFFF, 4);
      rd("R7 read 40", 12'h040);
      wr("R7 write 44", 12'h044, 32'hFFFF_FFFF, 4);
      rd("R7 read 44", 12'h044);
      wr("R7 write 50", 12'h050, 32'hFFFF_FFFF, 4);
      rd("R7 read 50", 12'h050);
      wr("R7 write 54", 12'h054, 32'hFFFF_FFFF, 4);
      rd("R7 read 54", 12'h054);
      wr("R7 write ff", 12'h0FF, 32'hFFFF_FFFF, 1);
      rd("R7 read ff", 12'h0FF);
      rd("R7 power unchanged", 12'h008);
      rd("R7 enable unchanged", 12'h000);

      // R8 hold and read-with-write
      rd("R8 load", 12'h008);
      cyc("R8 hold idle", 12'h000, 32'h0, 4, 1'b0, 1'b0);
      wr("R8 hold on write", 12'h008, 32'h0, 4);
      cyc("R8 read old on rw", 12'h008, 32'h5A5A_5A5A, 4, 1'b1, 1'b1);
      rd("R8 new value", 12'h008);

      // R9 aliasing
      wr("R9 alias write", 12'hF09, 32'h0000_00C3, 1);
      rd("R9 alias read", 12'h308);
      rd("R9 alias config", 12'hA04);

      // R1 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      m_ctrl = 0; m_pwr = 0; m_rdata = 0;
      check("R1 rdata cleared", bus_rdata, 32'h0);
      rst_n = 1'b1;
      rd("R1 power cleared", 12'h008);
      rd("R1 enable cleared", 12'h000);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule